// File: doc/BRIEF.md
# Pulse-Interval Reader Frame Decoder

This block recovers the bit stream of a reader-to-tag downlink that uses binary pulse length modulation. The reader briefly removes its field for each symbol, and the value of a symbol is carried only by how far apart successive field returns are. A synchronised copy of the field-gap signal goes into the decoder (high while the field is present), along with a one-cycle tick for every carrier period. The decoder measures the spacing between rising edges of that signal in whole carrier periods. It sorts each spacing into a zero bit, a one bit, a frame-start marker or noise.

Decoded bits are packed most significant bit first into a byte buffer. When no rising edge arrives for the end-of-frame timeout, the captured frame is handed out with its length, an overflow flag and the response time taken from the last start marker, and a one-cycle strobe marks it. The handed-out frame stays on the outputs until the next frame replaces it. A typical transmitter drops the field for 6 periods per symbol and spaces symbols 22 periods for a zero and 28 for a one. Command decoding happens downstream.

Top module: `bplm_frame_decoder`

## Requirements
- R1: An interval is the number of carrier ticks seen after one rising edge of `gap_in` and before the next. A tick in the same cycle as a rising edge is not counted, and every rising edge restarts the count, including one classified as noise.
- R2: An interval of 36 or more ticks is a start marker. It adds no bit and sets the pending response time to the interval minus 8. A later marker in the same frame overwrites it.
- R3: An interval of 25 to 35 ticks appends a one bit.
- R4: An interval of 15 to 24 ticks appends a zero bit.
- R5: An interval below 15 ticks adds no bit and leaves the pending response time unchanged.
- R6: On the tick that brings the count to 80 with no rising edge, the frame ends. If at least one bit was captured, `frame_done` pulses for exactly one cycle and `frame_data`, `frame_len`, `resp_units` and `frame_overflow` present that frame. These outputs then hold until the next reported frame. The working bit count, response time and overflow flag clear whether or not a frame was reported.
- R7: Byte k of a frame occupies `frame_data[8k+7:8k]`. Bit n of the frame (n from 0) sits at position 8*(n/8)+7-(n%8). Positions after the last bit read zero.
- R8: At most 160 bits are kept. Further bits are dropped and `frame_overflow` is set for that frame only.
- R9: The interval count saturates at 255, so an idle time of any length reads as 255 and a start marker after it reports 247.
- R10: When a rising edge arrives in the same cycle as the tick that would end the frame, the edge wins. It is classified with the count it sees (79, a start marker), and the frame goes on.
- R11: After reset, `frame_done` is low and `frame_data`, `frame_len`, `resp_units` and `frame_overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_in | input | 1 | Synchronised field-gap signal, high while the field is present |
| unit_tick | input | 1 | One-cycle pulse per carrier period |
| frame_data | output | 160 | Reported frame bytes, byte k at [8k+7:8k] |
| frame_len | output | 8 | Number of bits in the reported frame |
| frame_done | output | 1 | One-cycle strobe when a frame is reported |
| frame_overflow | output | 1 | Reported frame had more than 160 bits |
| resp_units | output | 8 | Response time from the last start marker of the reported frame |

## Verification
A rising edge and the end-of-frame timeout are the two events that can land in one cycle. The bench lets 79 carrier ticks pass after a bit and then raises `gap_in` in the very cycle that carries the 80th tick. The frame must not be reported there. The check is the frame that is reported later: it must hold the bits from both sides of the collision and a response time of 71, which shows that the edge was taken as a start marker.

// File: rtl/bplm_dec_pkg.sv
package bplm_dec_pkg;

  typedef enum logic [1:0] {
    SYM_NOISE = 2'd0,
    SYM_ZERO  = 2'd1,
    SYM_ONE   = 2'd2,
    SYM_START = 2'd3
  } sym_kind_e;

  // Sort a rise-to-rise spacing into a symbol kind against fixed limits.
  function automatic sym_kind_e classify_interval(input int unsigned iv,
                                                  input int unsigned zero_min,
                                                  input int unsigned one_min,
                                                  input int unsigned start_min);
    if (iv >= start_min)     return SYM_START;
    else if (iv >= one_min)  return SYM_ONE;
    else if (iv >= zero_min) return SYM_ZERO;
    else                     return SYM_NOISE;
  endfunction

  // Flat buffer position of frame bit n: byte n/8, most significant bit first.
  function automatic int unsigned bit_slot(input int unsigned n);
    return (n / 8) * 8 + 7 - (n % 8);
  endfunction

endpackage

// File: rtl/bplm_interval_timer.sv
module bplm_interval_timer #(
  parameter int CNT_W     = 8,
  parameter int EOF_UNITS = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_in,
  input  logic             unit_tick,
  output logic             rise,
  output logic [CNT_W-1:0] interval,
  output logic             eof_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(EOF_UNITS - 1);

  logic             gap_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise     = gap_in & ~gap_q;
  assign interval = cnt_q;
  assign eof_hit  = unit_tick & ~rise & (cnt_q == EOF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      gap_q <= gap_in;
      if (rise)
        cnt_q <= '0;
      else if (unit_tick && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt_q == '0);
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_tick && !rise && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !rise) |=> cnt_q == CNT_MAX);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_tick && !rise) |=> $stable(cnt_q));

endmodule

// File: rtl/bplm_symbol_classifier.sv
module bplm_symbol_classifier
  import bplm_dec_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ZERO_MIN  = 15,
  parameter int ONE_MIN   = 25,
  parameter int START_MIN = 36
) (
  input  logic             rise,
  input  logic [CNT_W-1:0] interval,
  output logic             bit_valid,
  output logic             bit_val,
  output logic             start_valid
);
  sym_kind_e kind;

  always_comb begin
    kind        = classify_interval(32'(interval), ZERO_MIN, ONE_MIN, START_MIN);
    bit_valid   = rise && (kind == SYM_ZERO || kind == SYM_ONE);
    bit_val     = (kind == SYM_ONE);
    start_valid = rise && (kind == SYM_START);
  end

  always_comb begin
    if (bit_valid) begin
      p_bit_floor_r4: assert (32'(interval) >= ZERO_MIN);
    end
    if (start_valid) begin
      p_start_floor_r2: assert (32'(interval) >= START_MIN);
    end
  end

endmodule

// File: rtl/bplm_bit_packer.sv
module bplm_bit_packer
  import bplm_dec_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_BITS  = 160,
  parameter int LOW_UNITS = 8,
  parameter int ZERO_MIN  = 15,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int IDX_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_in,
  input  logic [CNT_W-1:0]    interval,
  input  logic                bit_valid,
  input  logic                bit_val,
  input  logic                start_valid,
  input  logic                eof_hit,
  output logic [MAX_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]    frame_len,
  output logic                frame_done,
  output logic                frame_overflow,
  output logic [CNT_W-1:0]    resp_units
);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] work_data;
  logic [LEN_W-1:0]    work_len;
  logic [CNT_W-1:0]    work_resp;
  logic                work_ovf;
  logic [IDX_W-1:0]    slot;

  assign slot = IDX_W'(bit_slot(32'(work_len)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_data      <= '0;
      work_len       <= '0;
      work_resp      <= '0;
      work_ovf       <= 1'b0;
      frame_data     <= '0;
      frame_len      <= '0;
      frame_done     <= 1'b0;
      frame_overflow <= 1'b0;
      resp_units     <= '0;
    end else begin
      frame_done <= 1'b0;
      if (eof_hit) begin
        if (work_len != '0) begin
          frame_data     <= work_data;
          frame_len      <= work_len;
          frame_overflow <= work_ovf;
          resp_units     <= work_resp;
          frame_done     <= 1'b1;
        end
        work_data <= '0;
        work_len  <= '0;
        work_resp <= '0;
        work_ovf  <= 1'b0;
      end else begin
        if (start_valid)
          work_resp <= interval - CNT_W'(LOW_UNITS);
        if (bit_valid) begin
          if (work_len < LEN_FULL) begin
            work_data[slot] <= bit_val;
            work_len        <= work_len + 1'b1;
          end else begin
            work_ovf <= 1'b1;
          end
        end
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_done_has_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len != '0);
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(frame_len) && $stable(resp_units) && $stable(frame_overflow)));
  p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    work_ovf |-> work_len == LEN_FULL);
  p_noise_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_in && interval < CNT_W'(ZERO_MIN)) |=>
      (work_len == $past(work_len) && work_resp == $past(work_resp)));

endmodule

// File: rtl/bplm_frame_decoder.sv
module bplm_frame_decoder #(
  parameter int CNT_W     = 8,
  parameter int ZERO_MIN  = 15,
  parameter int ONE_MIN   = 25,
  parameter int START_MIN = 36,
  parameter int LOW_UNITS = 8,
  parameter int EOF_UNITS = 80,
  parameter int MAX_BYTES = 20,
  localparam int MAX_BITS = MAX_BYTES * 8,
  localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gap_in,
  input  logic                unit_tick,
  output logic [MAX_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]    frame_len,
  output logic                frame_done,
  output logic                frame_overflow,
  output logic [CNT_W-1:0]    resp_units
);
  logic             rise;
  logic [CNT_W-1:0] interval;
  logic             eof_hit;
  logic             bit_valid;
  logic             bit_val;
  logic             start_valid;

  bplm_interval_timer #(
    .CNT_W(CNT_W), .EOF_UNITS(EOF_UNITS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .gap_in(gap_in), .unit_tick(unit_tick),
    .rise(rise), .interval(interval), .eof_hit(eof_hit)
  );

  bplm_symbol_classifier #(
    .CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ONE_MIN(ONE_MIN), .START_MIN(START_MIN)
  ) u_class (
    .rise(rise), .interval(interval),
    .bit_valid(bit_valid), .bit_val(bit_val), .start_valid(start_valid)
  );

  bplm_bit_packer #(
    .CNT_W(CNT_W), .MAX_BITS(MAX_BITS), .LOW_UNITS(LOW_UNITS), .ZERO_MIN(ZERO_MIN)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .edge_in(rise), .interval(interval),
    .bit_valid(bit_valid), .bit_val(bit_val), .start_valid(start_valid),
    .eof_hit(eof_hit),
    .frame_data(frame_data), .frame_len(frame_len), .frame_done(frame_done),
    .frame_overflow(frame_overflow), .resp_units(resp_units)
  );

  p_edge_beats_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && unit_tick && interval == CNT_W'(EOF_UNITS - 1)) |=> !frame_done);

endmodule

// File: tb/sim_bplm_frame_decoder.sv
module sim_bplm_frame_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gap_in = 1'b1;
  logic         unit_tick = 1'b0;
  logic [159:0] frame_data;
  logic [7:0]   frame_len;
  logic         frame_done;
  logic         frame_overflow;
  logic [7:0]   resp_units;

  bplm_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .gap_in(gap_in), .unit_tick(unit_tick),
    .frame_data(frame_data), .frame_len(frame_len), .frame_done(frame_done),
    .frame_overflow(frame_overflow), .resp_units(resp_units)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [159:0] q_data[$];
  int           q_len[$];
  int           q_resp[$];
  bit           q_ovf[$];
  string        q_tag[$];

  // transaction model of the requirements
  int           since = 0;
  bit           prev_g = 1'b1;
  logic [159:0] m_data = '0;
  int           m_len = 0;
  int           m_resp = 0;
  bit           m_ovf = 1'b0;
  string        cur_tag = "R7";

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_add(input bit b);
    logic [7:0] idx;
    if (m_len < 160) begin
      idx = 8'(8 * (m_len / 8) + 7 - (m_len % 8));
      m_data[idx] = b;
      m_len++;
    end else begin
      m_ovf = 1'b1;
    end
  endtask

  task automatic model_rise(input int iv);
    if (iv >= 36)      m_resp = iv - 8;
    else if (iv >= 25) model_add(1'b1);
    else if (iv >= 15) model_add(1'b0);
  endtask

  task automatic model_eof();
    if (m_len > 0) begin
      q_data.push_back(m_data);
      q_len.push_back(m_len);
      q_resp.push_back(m_resp);
      q_ovf.push_back(m_ovf);
      q_tag.push_back(cur_tag);
    end
    m_data = '0; m_len = 0; m_resp = 0; m_ovf = 1'b0;
  endtask

  // one clock: drive tick and gap, update the model
  task automatic clk1(input bit t, input bit g);
    @(negedge clk);
    unit_tick = t;
    gap_in = g;
    if (g && !prev_g) begin
      model_rise(since);
      since = 0;
    end else if (t) begin
      if (since == 79) model_eof();
      if (since < 255) since++;
    end
    prev_g = g;
  endtask

  // one carrier period: tick cycle keeps the gap level, second cycle sets it
  task automatic unit(input bit g);
    clk1(1'b1, prev_g);
    clk1(1'b0, g);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) unit(1'b1);
  endtask

  // rising edge n carrier periods after the previous one (n >= 7)
  task automatic rise_after(input int n);
    idle(n - 7);
    for (int i = 0; i < 6; i++) unit(1'b0);
    unit(1'b1);
  endtask

  task automatic send_bits(input int n, input logic [63:0] pat);
    for (int i = 0; i < n; i++) rise_after(pat[i] ? 28 : 22);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && frame_done && !finished) begin
      if (q_len.size() == 0) begin
        check(1'b0, "R6", "unexpected frame len", int'(frame_len), 0);
      end else begin
        string tg;
        tg = q_tag.pop_front();
        check(frame_data == q_data[0], tg, "frame_data low word", int'(frame_data[31:0]), int'(q_data[0][31:0]));
        check(int'(frame_len) == q_len[0], tg, "frame_len", int'(frame_len), q_len[0]);
        check(int'(resp_units) == q_resp[0], tg, "resp_units", int'(resp_units), q_resp[0]);
        check(frame_overflow == q_ovf[0], tg, "frame_overflow", int'(frame_overflow), int'(q_ovf[0]));
        void'(q_data.pop_front());
        void'(q_len.pop_front());
        void'(q_resp.pop_front());
        void'(q_ovf.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(frame_done == 1'b0, "R11", "frame_done", int'(frame_done), 0);
    check(frame_len == 8'd0, "R11", "frame_len", int'(frame_len), 0);
    check(resp_units == 8'd0, "R11", "resp_units", int'(resp_units), 0);
    check(frame_data == '0 && frame_overflow == 1'b0, "R11", "data/overflow", int'(frame_data[31:0]), 0);

    // R2 R3 R4 R7: lead marker then 9 bits 1,0,1,1,0,0,1,0,1
    cur_tag = "R7";
    rise_after(40);
    send_bits(9, 64'b1_0100_1101);
    idle(90);
    check(frame_data[7:0] == 8'hB2 && frame_data[15:8] == 8'h80, "R7", "byte0/byte1",
          int'(frame_data[15:0]), 16'h80B2);

    // R6: marker only and noise only, no frame; outputs must hold
    rise_after(50);
    rise_after(10);
    idle(90);
    check(int'(frame_len) == 9, "R6", "held frame_len", int'(frame_len), 9);
    check(frame_data[7:0] == 8'hB2, "R6", "held byte0", int'(frame_data[7:0]), 8'hB2);

    // R2 R3 R4: boundary intervals 15,24,25,35, marker 36, then 22
    cur_tag = "R4";
    rise_after(40);
    rise_after(15); rise_after(24); rise_after(25); rise_after(35);
    rise_after(36);
    rise_after(22);
    idle(90);

    // R5: noise between bits restarts timing and adds nothing
    cur_tag = "R5";
    rise_after(40);
    rise_after(28); rise_after(14); rise_after(22); rise_after(10); rise_after(28);
    idle(90);

    // R9: long idle saturates, marker reports 247
    cur_tag = "R9";
    idle(300);
    rise_after(40);
    rise_after(28);
    idle(90);

    // R10: edge in the same cycle as the timeout tick
    cur_tag = "R10";
    rise_after(40);
    rise_after(28); rise_after(22);
    idle(72);
    for (int i = 0; i < 7; i++) unit(1'b0);
    clk1(1'b1, 1'b1);
    clk1(1'b0, 1'b1);
    rise_after(22); rise_after(28);
    idle(90);

    // R8: 165 bits, only 160 kept, overflow set
    cur_tag = "R8";
    rise_after(40);
    for (int i = 0; i < 165; i++) rise_after((i % 3 == 0) ? 28 : 22);
    idle(90);

    // R8: next frame has overflow clear
    cur_tag = "R8";
    rise_after(40);
    send_bits(3, 64'b011);
    idle(90);

    repeat (10) @(negedge clk);
    check(q_len.size() == 0, "R6", "missing frames", q_len.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule